// File: doc/BRIEF.md
# Chained Scatter-Gather List Builder

This block turns a buffer description into a chained scatter-gather list held in a local descriptor RAM. The description is given at `start`: where the list lives on the bus, the byte offset of the data inside its first page, the total byte count and the number of pages. The bus address of each page then arrives on a valid/ready stream, one address per page, in order. For each page the block writes a descriptor entry, or, when the page continues exactly where the previous piece ended, it lengthens the previous entry.

Entries are grouped into blocks of eight. The first slot of every block is a link to the following block and the other seven carry data. When the last page has been taken, a compaction pass reads every data entry of the final block and writes it back one slot lower. This removes the link that points nowhere. A terminator entry follows the moved entries. If the last page merged into an entry of the previous block, so that the final block holds nothing but its link, the compaction runs on the previous block instead. `done` pulses once the terminator has been written.

Top module: `sgl_chain_builder`

## Requirements
- R1: During and after reset, and until the next `start`, `done`, `pg_ready`, `ram_we` and `ram_re` are all low.
- R2: An entry is 128 bits: bus address in bits 127:64, length in bits 63:32 and flags in bits 31:0. With RAM byte 0 at bits 127:120, every field is stored big-endian. The flag codes are DATA = 0, LINK = 1 and END = 2. RAM index i is the entry at byte offset 16*i from `list_base`.
- R3: Every block has eight entries. Slot 0 of every block that is not the final one is a link entry whose address is `list_base + 128*(b+1)` for block b, whose length is 128 and whose flags are LINK.
- R4: A data entry for a page starts at the page address plus the current offset, and its length is min(remaining bytes, 4096 − offset). Only the first page uses `first_offs`. Every later page starts at offset 0.
- R5: When a piece starts at the byte just past the end of the previous data entry, no new entry is made. The previous entry's length grows by the piece length, and this also applies when that entry sits in the previous block.
- R6: After the last page, the data entries of the final block move up by one slot, which removes its link. An END entry (address 0, length 0) is written directly after them.
- R7: If the final block holds only its link when the last page is taken, the seven data entries of the previous block are moved up instead, and END goes into slot 7 of that block.
- R8: Each moved entry takes one RAM read. In the next cycle comes one RAM write of the data that was read, at the index one below the read index.
- R9: Every write falls inside the descriptor area: 16*(n + n/7 + 1) bytes for n pages, rounded up to whole 4096-byte pages.
- R10: A page address is taken only in a cycle with `pg_valid` and `pg_ready` both high. Exactly `page_cnt` addresses are taken, bubbles in `pg_valid` are tolerated, and `pg_ready` is low while no list is being built.
- R11: `done` is high for exactly one cycle, in the cycle after the END write. A `start` and any change of the description inputs while a list is being built have no effect on the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a list; sampled only when idle |
| list_base | input | 64 | Bus address of RAM index 0 |
| first_offs | input | PG_W | Byte offset of the data in the first page |
| total_bytes | input | 32 | Total byte count of the buffer |
| page_cnt | input | CNT_W | Number of pages, at least 1 |
| pg_valid | input | 1 | Page address is present |
| pg_addr | input | 64 | Bus address of the next page |
| pg_ready | output | 1 | Block takes a page address this cycle |
| ram_we | output | 1 | Descriptor RAM write enable |
| ram_waddr | output | IDX_W | Write entry index |
| ram_wdata | output | 128 | Entry to write |
| ram_re | output | 1 | Descriptor RAM read enable |
| ram_raddr | output | IDX_W | Read entry index |
| ram_rdata | input | 128 | Read data, one cycle after `ram_re` |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same step: a merge that lengthens an entry sitting in the previous block, and the last page itself. When they coincide, the compaction has to retarget the previous block. The bench provokes this with seven scattered pages followed by an eighth page that continues the seventh. In a second list, contiguous runs fall across block boundaries in the middle. The finished RAM image is judged against a behavioural model entry by entry, with END expected at slot 7 of the previous block. Each read-then-write move is also checked in the cycle it happens.

// File: rtl/sgl_pkg.sv
`timescale 1ns/1ps
package sgl_pkg;
    localparam int SLOTS     = 8;
    localparam int ENT_BYTES = 16;
    localparam int BLK_BYTES = SLOTS * ENT_BYTES;

    localparam logic [31:0] FLAG_DATA = 32'h0;
    localparam logic [31:0] FLAG_LINK = 32'h1;
    localparam logic [31:0] FLAG_END  = 32'h2;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] len;
        logic [31:0] flags;
    } sg_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LINK, ST_PAGE, ST_FOLD, ST_MVRD, ST_MVWR, ST_TERM
    } sg_state_t;

    typedef enum logic [2:0] {
        PO_HOLD, PO_CLEAR, PO_LINK, PO_ADV, PO_NEXT, PO_FOLD
    } ptr_op_t;

    // Entries reserved for a list of the given page count.
    function automatic int unsigned area_entries(int unsigned pages, int unsigned page_bytes);
        int unsigned bytes;
        bytes = ENT_BYTES * (pages + pages / 7 + 1);
        return ((bytes + page_bytes - 1) / page_bytes) * (page_bytes / ENT_BYTES);
    endfunction
endpackage

// File: rtl/sgl_piece_calc.sv
`timescale 1ns/1ps
module sgl_piece_calc #(
    parameter int PG_W = 12
) (
    input  logic [63:0]     pg_addr,
    input  logic [PG_W-1:0] offs,
    input  logic [31:0]     rem,
    input  logic            have_prev,
    input  logic [63:0]     prev_end,
    output logic [63:0]     daddr,
    output logic [31:0]     size,
    output logic            merge
);
    logic [PG_W:0] avail;

    always_comb begin
        avail = {1'b1, {PG_W{1'b0}}} - {1'b0, offs};
        daddr = pg_addr + 64'(offs);
        size  = (rem < 32'(avail)) ? rem : 32'(avail);
        merge = have_prev && (daddr == prev_end);
    end
endmodule

// File: rtl/sgl_slot_ptr.sv
`timescale 1ns/1ps
module sgl_slot_ptr
    import sgl_pkg::*;
#(
    parameter int IDX_W = 10,
    localparam int BLK_W = IDX_W - 3
) (
    input  logic             clk,
    input  logic             rst,
    input  ptr_op_t          op,
    output logic [BLK_W-1:0] blk,
    output logic [3:0]       slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            blk  <= '0;
            slot <= '0;
        end else begin
            case (op)
                PO_CLEAR: begin blk <= '0; slot <= 4'd0; end
                PO_LINK:  slot <= 4'd1;
                PO_ADV:   slot <= slot + 4'd1;
                PO_NEXT:  begin blk <= blk + 1'b1; slot <= 4'd0; end
                PO_FOLD:  if (slot == 4'd1) begin
                              blk  <= blk - 1'b1;
                              slot <= 4'd8;
                          end
                default:  ;
            endcase
        end
    end

    // R3: a block never holds more than eight entries
    a_r3_slot_bound: assert property (@(posedge clk) disable iff (rst)
        slot <= 4'd8);

    // R7: a final block with only its link folds onto slot 8 of the previous block
    a_r7_fold_target: assert property (@(posedge clk) disable iff (rst)
        (op == PO_FOLD && slot == 4'd1) |=> (slot == 4'd8));
endmodule

// File: rtl/sgl_chain_builder.sv
`timescale 1ns/1ps
module sgl_chain_builder
    import sgl_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int PG_W  = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [63:0]      list_base,
    input  logic [PG_W-1:0]  first_offs,
    input  logic [31:0]      total_bytes,
    input  logic [CNT_W-1:0] page_cnt,
    input  logic             pg_valid,
    input  logic [63:0]      pg_addr,
    output logic             pg_ready,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_waddr,
    output logic [127:0]     ram_wdata,
    output logic             ram_re,
    output logic [IDX_W-1:0] ram_raddr,
    input  logic [127:0]     ram_rdata,
    output logic             done
);
    localparam int BLK_W      = IDX_W - 3;
    localparam int PAGE_BYTES = 1 << PG_W;

    sg_state_t        state;
    ptr_op_t          op;
    logic [BLK_W-1:0] blk;
    logic [3:0]       slot;
    logic [63:0]      base_q, prev_end_q, last_addr_q;
    logic [CNT_W-1:0] pcnt_q, taken_q;
    logic [31:0]      rem_q, last_len_q;
    logic [PG_W-1:0]  offs_q;
    logic             have_prev_q, done_q;
    logic [IDX_W-1:0] last_idx_q;
    logic [3:0]       mv_q;

    logic [63:0]      daddr;
    logic [31:0]      psize;
    logic             merge;
    logic [IDX_W-1:0] blk_base, cur_idx;
    logic             last_pg, take;
    sg_ent_t          wr_ent;

    sgl_piece_calc #(.PG_W(PG_W)) u_piece (
        .pg_addr(pg_addr), .offs(offs_q), .rem(rem_q),
        .have_prev(have_prev_q), .prev_end(prev_end_q),
        .daddr(daddr), .size(psize), .merge(merge)
    );

    sgl_slot_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst(rst), .op(op), .blk(blk), .slot(slot)
    );

    assign blk_base = {blk, 3'b000};
    assign cur_idx  = blk_base + IDX_W'(slot);
    assign last_pg  = (taken_q + CNT_W'(1)) == pcnt_q;
    assign take     = (state == ST_PAGE) && pg_valid;
    assign pg_ready = (state == ST_PAGE);
    assign done     = done_q;
    assign ram_wdata = wr_ent;

    always_comb begin
        op        = PO_HOLD;
        ram_we    = 1'b0;
        ram_waddr = '0;
        wr_ent    = '0;
        ram_re    = 1'b0;
        ram_raddr = '0;
        case (state)
            ST_IDLE: if (start) op = PO_CLEAR;
            ST_LINK: begin
                op        = PO_LINK;
                ram_we    = 1'b1;
                ram_waddr = blk_base;
                wr_ent    = '{addr: base_q + ((64'(blk) + 64'd1) << 7),
                              len: 32'(BLK_BYTES), flags: FLAG_LINK};
            end
            ST_PAGE: if (pg_valid) begin
                ram_we = 1'b1;
                if (merge) begin
                    ram_waddr = last_idx_q;
                    wr_ent    = '{addr: last_addr_q, len: last_len_q + psize, flags: FLAG_DATA};
                end else begin
                    ram_waddr = cur_idx;
                    wr_ent    = '{addr: daddr, len: psize, flags: FLAG_DATA};
                    op        = (slot == 4'd7 && !last_pg) ? PO_NEXT : PO_ADV;
                end
            end
            ST_FOLD: op = PO_FOLD;
            ST_MVRD: begin
                ram_re    = 1'b1;
                ram_raddr = blk_base + IDX_W'(mv_q);
            end
            ST_MVWR: begin
                ram_we    = 1'b1;
                ram_waddr = blk_base + IDX_W'(mv_q) - IDX_W'(1);
                wr_ent    = sg_ent_t'(ram_rdata);
            end
            ST_TERM: begin
                ram_we    = 1'b1;
                ram_waddr = cur_idx - IDX_W'(1);
                wr_ent    = '{addr: 64'd0, len: 32'd0, flags: FLAG_END};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            base_q      <= '0;
            pcnt_q      <= '0;
            taken_q     <= '0;
            rem_q       <= '0;
            offs_q      <= '0;
            have_prev_q <= 1'b0;
            prev_end_q  <= '0;
            last_addr_q <= '0;
            last_len_q  <= '0;
            last_idx_q  <= '0;
            mv_q        <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= (state == ST_TERM);
            case (state)
                ST_IDLE: if (start) begin
                    base_q      <= list_base;
                    pcnt_q      <= page_cnt;
                    taken_q     <= '0;
                    rem_q       <= total_bytes;
                    offs_q      <= first_offs;
                    have_prev_q <= 1'b0;
                    state       <= ST_LINK;
                end
                ST_LINK: state <= ST_PAGE;
                ST_PAGE: if (take) begin
                    taken_q     <= taken_q + CNT_W'(1);
                    rem_q       <= rem_q - psize;
                    offs_q      <= '0;
                    prev_end_q  <= daddr + 64'(psize);
                    have_prev_q <= 1'b1;
                    if (merge) begin
                        last_len_q <= last_len_q + psize;
                    end else begin
                        last_addr_q <= daddr;
                        last_len_q  <= psize;
                        last_idx_q  <= cur_idx;
                    end
                    if (last_pg)                        state <= ST_FOLD;
                    else if (!merge && slot == 4'd7)    state <= ST_LINK;
                end
                ST_FOLD: begin
                    mv_q  <= 4'd1;
                    state <= ST_MVRD;
                end
                ST_MVRD: state <= ST_MVWR;
                ST_MVWR: begin
                    mv_q  <= mv_q + 4'd1;
                    state <= ((mv_q + 4'd1) == slot) ? ST_TERM : ST_MVRD;
                end
                ST_TERM: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: the first write of a list is the link entry at index 0
    a_r3_link_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=>
            (ram_we && ram_waddr == '0 && ram_wdata[31:0] == FLAG_LINK
             && ram_wdata[63:32] == 32'(BLK_BYTES)));

    // R8: a move write lands one index below the read of the previous cycle
    a_r8_move_pair: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MVWR) |-> ($past(ram_re) && (ram_waddr + IDX_W'(1)) == $past(ram_raddr)));

    // R9: every write stays inside the descriptor area
    a_r9_in_area: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (32'(ram_waddr) < area_entries(32'(pcnt_q), PAGE_BYTES)));

    // R10: no page is taken beyond the announced count
    a_r10_no_extra_page: assert property (@(posedge clk) disable iff (rst)
        (pg_valid && pg_ready) |-> (taken_q < pcnt_q));
endmodule

// File: tb/sgl_chain_builder_bench.sv
`timescale 1ns/1ps
module sgl_chain_builder_bench;
    localparam int IDX_W = 10;
    localparam int PG_W  = 12;
    localparam int CNT_W = 16;
    localparam int PB    = 4096;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [63:0]      list_base = '0;
    logic [PG_W-1:0]  first_offs = '0;
    logic [31:0]      total_bytes = '0;
    logic [CNT_W-1:0] page_cnt = '0;
    logic             pg_valid = 1'b0;
    logic [63:0]      pg_addr = '0;
    logic             pg_ready, ram_we, ram_re, done;
    logic [IDX_W-1:0] ram_waddr, ram_raddr;
    logic [127:0]     ram_wdata;
    logic [127:0]     ram_rdata = '0;

    sgl_chain_builder #(.IDX_W(IDX_W), .PG_W(PG_W), .CNT_W(CNT_W)) u_sgl_chain_builder (
        .clk(clk), .rst(rst), .start(start), .list_base(list_base),
        .first_offs(first_offs), .total_bytes(total_bytes), .page_cnt(page_cnt),
        .pg_valid(pg_valid), .pg_addr(pg_addr), .pg_ready(pg_ready),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .done(done)
    );

    always #10 clk = ~clk;

    logic [127:0] mem  [DEPTH];
    logic [127:0] expv [DEPTH];
    logic [63:0]  pg_list [64];
    int           n_cur = 1;
    int           end_idx = 0;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           busy = 1'b0;
    bit           case_go = 1'b0;
    bit           clear_mem = 1'b0;
    int           acc_cnt = 0;
    bit           re_d = 1'b0;
    logic [IDX_W-1:0] raddr_d = '0;

    // descriptor RAM and bench-side bookkeeping
    always @(posedge clk) begin
        if (clear_mem) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= {128{1'b1}};
        end else if (ram_we) begin
            mem[ram_waddr] <= ram_wdata;
        end
        if (ram_re) ram_rdata <= mem[ram_raddr];
        re_d    <= ram_re;
        raddr_d <= ram_raddr;
        if (case_go)                    acc_cnt <= 0;
        else if (pg_valid && pg_ready)  acc_cnt <= acc_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expd);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expd);
        end
    endtask

    function automatic int area_b(input int n);
        int bytes;
        bytes = 16 * (n + n / 7 + 1);
        return ((bytes + PB - 1) / PB) * (PB / 16);
    endfunction

    // every-clock checks
    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we)
                check(int'(ram_waddr) < area_b(n_cur), "R9", "write index in area",
                      128'(ram_waddr), 128'(area_b(n_cur)));
            if (!busy)
                check(!pg_ready, "R10", "ready while idle", 128'(pg_ready), 128'(0));
            if (re_d) begin
                check(ram_we && ram_waddr == raddr_d - 1'b1, "R8", "move write index",
                      {ram_we, 32'(ram_waddr)}, {1'b1, 32'(raddr_d - 1'b1)});
                check(ram_wdata == ram_rdata, "R8", "move write data", ram_wdata, ram_rdata);
            end
        end
    end

    // behavioural list model
    task automatic build_model(input logic [63:0] base, input int offs, input int size, input int n);
        int blk = 0, j = 0, p = 0, last = 0, sz;
        longint rem = size, mo = offs;
        logic [63:0] prev = '0, d;
        bit hp = 0, fin = 0;
        for (int i = 0; i < DEPTH; i++) expv[i] = '0;
        while (!fin) begin
            expv[blk * 8] = {base + 64'((blk + 1) * 128), 32'd128, 32'd1};
            j = 1;
            while (j < 8 && !fin) begin
                sz = (rem < PB - mo) ? int'(rem) : int'(PB - mo);
                d  = pg_list[p] + 64'(mo);
                rem -= sz;
                mo = 0;
                if (hp && d == prev) begin
                    expv[last][63:32] = expv[last][63:32] + 32'(sz);
                end else begin
                    expv[blk * 8 + j] = {d, 32'(sz), 32'd0};
                    last = blk * 8 + j;
                    j++;
                end
                hp = 1;
                prev = d + 64'(sz);
                p++;
                if (p == n) fin = 1;
            end
            if (!fin) blk++;
        end
        if (j == 1) begin blk--; j = 8; end
        for (int k = 1; k < j; k++) expv[blk * 8 + k - 1] = expv[blk * 8 + k];
        expv[blk * 8 + j - 1] = {64'd0, 32'd0, 32'd2};
        end_idx = blk * 8 + j - 1;
    endtask

    task automatic run_case(input logic [63:0] base, input int offs, input int size,
                            input int n, input int gap, input bit poke,
                            input string dtag, input string etag);
        int t = 0;
        build_model(base, offs, size, n);
        n_cur = n;
        @(negedge clk);
        clear_mem = 1'b1;
        case_go   = 1'b1;
        @(negedge clk);
        clear_mem   = 1'b0;
        case_go     = 1'b0;
        list_base   = base;
        first_offs  = PG_W'(offs);
        total_bytes = 32'(size);
        page_cnt    = CNT_W'(n);
        start = 1'b1;
        busy  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 5000) begin
            pg_valid = (acc_cnt < n) && (gap == 0 || (t % gap) != 0);
            pg_addr  = (acc_cnt < n) ? pg_list[acc_cnt] : 64'd0;
            if (poke && t == 6) begin
                // R11: start and new description while building must be ignored
                start = 1'b1; list_base = 64'hDEAD_0000; first_offs = '0;
                total_bytes = 32'd1; page_cnt = CNT_W'(1);
            end else begin
                start = 1'b0; list_base = base; first_offs = PG_W'(offs);
                total_bytes = 32'(size); page_cnt = CNT_W'(n);
            end
            @(negedge clk);
            t++;
        end
        start    = 1'b0;
        pg_valid = 1'b0;
        busy     = 1'b0;
        check(done == 1'b1, "R11", "done seen", 128'(done), 128'(1));
        check(acc_cnt == n, "R10", "pages taken", 128'(acc_cnt), 128'(n));
        for (int i = 0; i <= end_idx; i++) begin
            if (expv[i][31:0] == 32'd1)
                check(mem[i] == expv[i], "R3", $sformatf("link entry %0d", i), mem[i], expv[i]);
            else if (expv[i][31:0] == 32'd2)
                check(mem[i] == expv[i], etag, $sformatf("end entry %0d", i), mem[i], expv[i]);
            else
                check(mem[i] == expv[i], dtag, $sformatf("data entry %0d", i), mem[i], expv[i]);
        end
        @(negedge clk);
        check(done == 1'b0, "R11", "done width", 128'(done), 128'(0));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!done && !pg_ready && !ram_we && !ram_re, "R1", "outputs in reset",
              {done, pg_ready, ram_we, ram_re}, 128'(0));
        rst = 1'b0;
        @(negedge clk);
        check(!done && !pg_ready && !ram_we && !ram_re, "R1", "outputs after reset",
              {done, pg_ready, ram_we, ram_re}, 128'(0));

        // R2: single partial page with an offset
        pg_list[0] = 64'h1_0000_0000;
        run_case(64'h8000_0000, 100, 50, 1, 0, 0, "R2", "R6");

        // R4: scattered pages, first one offset
        pg_list[0] = 64'h10000; pg_list[1] = 64'h30000; pg_list[2] = 64'h50000;
        run_case(64'h8000_0000, 2048, 8192, 3, 3, 0, "R4", "R6");

        // R5: fully contiguous run merges into one entry
        for (int i = 0; i < 4; i++) pg_list[i] = 64'h20_0000 + 64'(i * PB);
        run_case(64'h4000_0000, 16, 4 * PB - 16 - 256, 4, 0, 0, "R5", "R6");

        // R6: exactly one full block of seven scattered pages
        for (int i = 0; i < 7; i++) pg_list[i] = 64'h100_0000 + 64'(i * 64'h2_0000);
        run_case(64'h8000_0000, 0, 7 * PB, 7, 2, 0, "R4", "R6");

        // R7: eighth page merges into the previous block, final block folds
        for (int i = 0; i < 7; i++) pg_list[i] = 64'h300_0000 + 64'(i * 64'h2_0000);
        pg_list[7] = pg_list[6] + 64'(PB);
        run_case(64'h8000_0000, 0, 8 * PB, 8, 0, 0, "R5", "R7");

        // R5: mixed runs across several blocks
        for (int i = 0; i < 20; i++)
            pg_list[i] = (i % 3 == 2) ? pg_list[i - 1] + 64'(PB) : 64'h1000_0000 + 64'(i * 64'h1_0000);
        run_case(64'h9000_0000, 'h234, 20 * PB - 'h234 - 'h500, 20, 4, 0, "R5", "R6");

        // R11: start while building is ignored
        pg_list[0] = 64'h10000; pg_list[1] = 64'h30000; pg_list[2] = 64'h50000;
        run_case(64'hA000_0000, 2048, 8192, 3, 2, 1, "R11", "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule